// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent memory ports and a shared word store. Each clock it checks whether both ports are enabled and aimed at the same word. When they are, the port that was already parked on that word keeps its access. The other port sees an active-low busy flag in the same cycle, and any write it attempts is dropped. Reads are not blocked, and a read from the busy port still returns the stored word. Whether an access is a read or a write has no effect on the decision.

A mode input selects the role. In master mode the block runs the arbitration, drives both busy outputs and ignores the busy inputs. In slave mode the busy outputs stay high and each busy input acts only as a write inhibit for its own port. Several blocks can share one decision this way: one master decides, and the slaves follow its busy lines. A parameter picks a half-depth setting in which the top address bit is ignored, both for matching and for indexing the store. The store is synchronous. An enabled access loads the port's read register on the next edge.

Top module: `dp_collision_arbiter`

## Requirements
- R1: A collision exists only when both ports are enabled and their compared addresses are equal, whatever the write-enable of either port. Without a collision both busy outputs are high (1 = not busy).
- R2: A port is "settled" when it was enabled at the same compared address in the previous cycle. On a new collision, a settled port wins over an unsettled one, and the losing port's busy output goes low in the same cycle the collision appears.
- R3: The two busy outputs are never low together. When neither port is settled at a new collision (both arrive in the same cycle), the left port wins and the right busy output goes low.
- R4: In master mode a write from the port whose busy output is low is not performed. The busy inputs have no effect in master mode, whatever their level.
- R5: In slave mode (master_mode = 0) both busy outputs stay high. A low busy input blocks only that port's writes, and reads are unaffected.
- R6: With HALF_DEPTH = 1 the top address bit is excluded from the collision compare and from the store index, so addresses differing only in that bit alias.
- R7: While both ports stay enabled at unchanged matching addresses, the grant is held. Busy releases in the same cycle the addresses stop matching or either port is disabled.
- R8: An enabled read from a busy port still loads that port's read data.
- R9: An enabled port loads its read data on the next clock edge with the word stored before that edge. Writes take effect at the edge. When both ports write the same word unblocked in one cycle, the right port's value is kept. Read data is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = decide and drive busy, 0 = follow busy inputs |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write enable |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_busy_n_in | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_out | output | 1 | Left busy flag, active low |
| l_rdata | output | DATA_W | Left port read data |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write enable |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_busy_n_in | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_out | output | 1 | Right busy flag, active low |
| r_rdata | output | DATA_W | Right port read data |

## Verification
The bench builds two copies that share one stimulus, both with ADDR_W = 6 and DATA_W = 18. One copy uses HALF_DEPTH = 0 and the other HALF_DEPTH = 1. The narrow address makes it cheap to fill the whole store and to aim random traffic at a handful of words, so collisions, ties and held grants occur often. Running the two copies side by side shows the aliasing case: a pair of addresses that differ only in the top bit collides in one copy and not in the other within the same cycle.

// File: rtl/dpca_pkg.sv
// Shared types for the dual-port collision arbiter.
// Assumes nothing beyond a single clock domain.
package dpca_pkg;

    // Which port currently holds the grant on a colliding word
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpca_match.sv
// Address match unit: masks each port's address to its compared key
// and flags a collision when both ports are enabled on equal keys.
// Assumes HALF_DEPTH selects whether the top address bit is ignored.
module dpca_match #(
    parameter int ADDR_W     = 12,
    parameter bit HALF_DEPTH = 1'b0
) (
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic [ADDR_W-1:0] l_key,
    output logic [ADDR_W-1:0] r_key,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] KEY_MASK =
        HALF_DEPTH ? {1'b0, {(ADDR_W-1){1'b1}}} : {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] bit_eq;

    // Masked keys used for both compare and storage index
    always_comb begin
        l_key = l_addr & KEY_MASK;
        r_key = r_addr & KEY_MASK;
    end

    // Per-bit equality of the two keys
    for (genvar b = 0; b < ADDR_W; b++) begin : g_eq
        assign bit_eq[b] = ~(l_key[b] ^ r_key[b]);
    end

    // Collision needs both ports enabled and all key bits equal
    always_comb begin
        hit = l_en & r_en & (&bit_eq);
    end

endmodule

// File: rtl/dpca_grant.sv
// Grant unit: remembers each port's previous enable and key, decides
// which port wins a collision, holds that choice while the collision
// persists, and produces busy outputs and internal write inhibits.
// Assumes busy is evaluated in the same cycle as the inputs it reacts to.
module dpca_grant
    import dpca_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_key,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_key,
    input  logic              hit,
    input  logic              l_busy_n_in,
    input  logic              r_busy_n_in,
    output logic              l_busy_n_out,
    output logic              r_busy_n_out,
    output logic              l_inhibit,
    output logic              r_inhibit
);

    owner_e            own_q;
    owner_e            win;
    logic              l_en_q;
    logic              r_en_q;
    logic [ADDR_W-1:0] l_key_q;
    logic [ADDR_W-1:0] r_key_q;
    logic              l_steady;
    logic              r_steady;
    logic              l_lose;
    logic              r_lose;

    // A port is settled when it was enabled on the same key last cycle
    always_comb begin
        l_steady = l_en & l_en_q & (l_key == l_key_q);
        r_steady = r_en & r_en_q & (r_key == r_key_q);
    end

    // Pick the winner: hold an existing grant, else favour the settled port, tie to left
    always_comb begin
        win = OWN_NONE;
        if (hit) begin
            if ((own_q != OWN_NONE) && l_steady && r_steady) begin
                win = own_q;
            end else if (r_steady && !l_steady) begin
                win = OWN_RIGHT;
            end else begin
                win = OWN_LEFT;
            end
        end
    end

    // Losing side of a live collision
    always_comb begin
        l_lose = hit & (win == OWN_RIGHT);
        r_lose = hit & (win == OWN_LEFT);
    end

    // Busy drive in master mode only; inhibit from own decision or external pin
    always_comb begin
        l_busy_n_out = ~(master_mode & l_lose);
        r_busy_n_out = ~(master_mode & r_lose);
        l_inhibit    = master_mode ? l_lose : ~l_busy_n_in;
        r_inhibit    = master_mode ? r_lose : ~r_busy_n_in;
    end

    // History registers: previous enables, keys and grant owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q   <= OWN_NONE;
            l_en_q  <= 1'b0;
            r_en_q  <= 1'b0;
            l_key_q <= '0;
            r_key_q <= '0;
        end else begin
            own_q   <= win;
            l_en_q  <= l_en;
            r_en_q  <= r_en;
            l_key_q <= l_key;
            r_key_q <= r_key;
        end
    end

    // R3
    no_dual_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n_out && !r_busy_n_out));

    // R7
    held_grant_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && hit && $past(hit) &&
         $stable(l_key) && $stable(r_key) && $past(!r_busy_n_out)) |-> !r_busy_n_out);

    // R7
    held_grant_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && hit && $past(hit) &&
         $stable(l_key) && $stable(r_key) && $past(!l_busy_n_out)) |-> !l_busy_n_out);

    // R5
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n_out && r_busy_n_out));

endmodule

// File: rtl/dpca_store.sv
// Word store with one read/write access per port per cycle.
// Writes are dropped when the port's inhibit is high. Read data is
// registered and returns the word as it was before the same edge.
// Assumes keys are already masked to the active depth.
module dpca_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_key,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_inhibit,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_key,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_inhibit,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              l_wr_fire,
    output logic              r_wr_fire
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Qualified write strobes
    always_comb begin
        l_wr_fire = l_en & l_we & ~l_inhibit;
        r_wr_fire = r_en & r_we & ~r_inhibit;
    end

    // Array update; right port written last so it wins a same-word clash
    always_ff @(posedge clk) begin
        if (l_wr_fire) begin
            mem[l_key] <= l_wdata;
        end
        if (r_wr_fire) begin
            mem[r_key] <= r_wdata;
        end
    end

    // Registered read data for each enabled port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_en) begin
                l_rdata <= mem[l_key];
            end
            if (r_en) begin
                r_rdata <= mem[r_key];
            end
        end
    end

endmodule

// File: rtl/dp_collision_arbiter.sv
// Top level: dual-port collision arbiter with its shared word store.
// Master mode decides and drives busy; slave mode follows busy inputs
// as write inhibits. Assumes a single clock and synchronous reset.
module dp_collision_arbiter #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 18,
    parameter bit HALF_DEPTH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_n_in,
    output logic              l_busy_n_out,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_n_in,
    output logic              r_busy_n_out,
    output logic [DATA_W-1:0] r_rdata
);

    logic [ADDR_W-1:0] l_key;
    logic [ADDR_W-1:0] r_key;
    logic              hit;
    logic              l_inhibit;
    logic              r_inhibit;
    logic              l_wr_fire;
    logic              r_wr_fire;

    dpca_match #(
        .ADDR_W     (ADDR_W),
        .HALF_DEPTH (HALF_DEPTH)
    ) i_match (
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .l_key  (l_key),
        .r_key  (r_key),
        .hit    (hit)
    );

    dpca_grant #(
        .ADDR_W (ADDR_W)
    ) i_grant (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_mode  (master_mode),
        .l_en         (l_en),
        .l_key        (l_key),
        .r_en         (r_en),
        .r_key        (r_key),
        .hit          (hit),
        .l_busy_n_in  (l_busy_n_in),
        .r_busy_n_in  (r_busy_n_in),
        .l_busy_n_out (l_busy_n_out),
        .r_busy_n_out (r_busy_n_out),
        .l_inhibit    (l_inhibit),
        .r_inhibit    (r_inhibit)
    );

    dpca_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .l_en      (l_en),
        .l_we      (l_we),
        .l_key     (l_key),
        .l_wdata   (l_wdata),
        .l_inhibit (l_inhibit),
        .r_en      (r_en),
        .r_we      (r_we),
        .r_key     (r_key),
        .r_wdata   (r_wdata),
        .r_inhibit (r_inhibit),
        .l_rdata   (l_rdata),
        .r_rdata   (r_rdata),
        .l_wr_fire (l_wr_fire),
        .r_wr_fire (r_wr_fire)
    );

    // R1
    busy_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en || !r_en) |-> (l_busy_n_out && r_busy_n_out));

    // R4
    left_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !l_busy_n_out) |-> !l_wr_fire);

    // R4
    right_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !r_busy_n_out) |-> !r_wr_fire);

    // R5
    slave_left_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !l_busy_n_in) |-> !l_wr_fire);

    // R5
    slave_right_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !r_busy_n_in) |-> !r_wr_fire);

endmodule

// File: tb/test_dp_collision_arbiter.sv
module test_dp_collision_arbiter;

    localparam int AW = 6;
    localparam int DW = 18;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          master_mode = 1'b1;
    logic          l_en = 0, l_we = 0, r_en = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic          l_bin = 1'b1, r_bin = 1'b1;

    logic          m_lbo, m_rbo, h_lbo, h_rbo;
    logic [DW-1:0] m_lrd, m_rrd, h_lrd, h_rrd;

    dp_collision_arbiter #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b0)) i_dp_collision_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_busy_n_in(l_bin), .l_busy_n_out(m_lbo), .l_rdata(m_lrd),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_busy_n_in(r_bin), .r_busy_n_out(m_rbo), .r_rdata(m_rrd));

    dp_collision_arbiter #(.ADDR_W(AW), .DATA_W(DW), .HALF_DEPTH(1'b1)) i_dp_collision_arbiter_half (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_busy_n_in(l_bin), .l_busy_n_out(h_lbo), .l_rdata(h_lrd),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_busy_n_in(r_bin), .r_busy_n_out(h_rbo), .r_rdata(h_rrd));

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // next-cycle settings applied inside step
    logic nm = 1'b1, nbl = 1'b1, nbr = 1'b1;

    // reference model state, index 0 = full depth, 1 = half depth
    int            own [2];
    bit            pl_en [2], pr_en [2];
    int            pl_a [2], pr_a [2];
    logic [DW-1:0] mdl [2][NW];
    logic [DW-1:0] e_lrd [2], e_rrd [2];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 1021 + 77) & 32'h3FFFF);
    endfunction

    task automatic model_cycle(string tag, int k);
        int  msk = (k == 1) ? (NW/2 - 1) : (NW - 1);
        int  la = int'(l_addr) & msk;
        int  ra = int'(r_addr) & msk;
        bit  hit = l_en && r_en && (la == ra);
        bit  ls = l_en && pl_en[k] && (la == pl_a[k]);
        bit  rs = r_en && pr_en[k] && (ra == pr_a[k]);
        int  w = 0;
        bit  bl, br, il, ir;
        if (hit) begin
            if (own[k] != 0 && ls && rs) w = own[k];
            else if (ls && !rs) w = 1;
            else if (rs && !ls) w = 2;
            else w = 1;
        end
        bl = master_mode && hit && (w == 2);
        br = master_mode && hit && (w == 1);
        il = master_mode ? bl : !l_bin;
        ir = master_mode ? br : !r_bin;
        if (k == 0) begin
            chk(tag, "full l_busy_n", 32'(m_lbo), 32'(!bl));
            chk(tag, "full r_busy_n", 32'(m_rbo), 32'(!br));
            chk(tag, "full l_rdata", 32'(m_lrd), 32'(e_lrd[0]));
            chk(tag, "full r_rdata", 32'(m_rrd), 32'(e_rrd[0]));
        end else begin
            chk(tag, "half l_busy_n", 32'(h_lbo), 32'(!bl));
            chk(tag, "half r_busy_n", 32'(h_rbo), 32'(!br));
            chk(tag, "half l_rdata", 32'(h_lrd), 32'(e_lrd[1]));
            chk(tag, "half r_rdata", 32'(h_rrd), 32'(e_rrd[1]));
        end
        // state after the coming edge
        if (l_en) e_lrd[k] = mdl[k][la];
        if (r_en) e_rrd[k] = mdl[k][ra];
        if (l_en && l_we && !il) mdl[k][la] = l_wdata;
        if (r_en && r_we && !ir) mdl[k][ra] = r_wdata;
        own[k] = w;
        pl_en[k] = l_en; pl_a[k] = la;
        pr_en[k] = r_en; pr_a[k] = ra;
    endtask

    task automatic step(string tag, bit le, bit lw, int la, int ld,
                        bit re, bit rw, int ra, int rd);
        @(negedge clk);
        master_mode = nm; l_bin = nbl; r_bin = nbr;
        l_en = le; l_we = lw; l_addr = AW'(la); l_wdata = DW'(ld);
        r_en = re; r_we = rw; r_addr = AW'(ra); r_wdata = DW'(rd);
        #1;
        model_cycle(tag, 0);
        model_cycle(tag, 1);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            own[k] = 0; pl_en[k] = 0; pr_en[k] = 0; pl_a[k] = 0; pr_a[k] = 0;
            e_lrd[k] = '0; e_rrd[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9", "reset l_rdata", 32'(m_lrd), 0);
        chk("R9", "reset r_rdata", 32'(m_rrd), 0);
        chk("R9", "reset l_busy_n", 32'(m_lbo), 1);
        chk("R9", "reset r_busy_n", 32'(h_rbo), 1);
        rst_n = 1'b1;

        // R9 fill the store through the left port
        for (int a = 0; a < NW; a++) step("R9", 1, 1, a, int'(pat(a)), 0, 0, 0, 0);
        step("R9", 1, 0, 10, 0, 1, 0, 20, 0);
        idle("R9");

        // R1 same word, both reads, both new: collision anyway
        step("R1", 1, 0, 7, 0, 1, 0, 7, 0);
        idle("R1");
        step("R1", 1, 1, 8, 111, 1, 0, 9, 0);
        step("R1", 1, 1, 8, 222, 1, 1, 9, 333);
        idle("R1");

        // R2 left settled first, right write blocked
        step("R2", 1, 0, 12, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 12, 0, 1, 1, 12, 4444);
        step("R4", 1, 0, 12, 0, 1, 1, 12, 5555);
        idle("R4");
        step("R4", 0, 0, 0, 0, 1, 0, 12, 0);
        idle("R4");
        // R2 right settled first, left write blocked
        step("R2", 0, 0, 0, 0, 1, 0, 14, 0);
        step("R2", 1, 1, 14, 777, 1, 0, 14, 0);
        idle("R2");
        step("R2", 1, 0, 14, 0, 0, 0, 0, 0);
        idle("R2");

        // R3 tie: both write same word in one cycle
        step("R3", 1, 1, 16, 1234, 1, 1, 16, 4321);
        idle("R3");
        step("R3", 1, 0, 16, 0, 1, 0, 17, 0);
        idle("R3");

        // R7 hold, then release on disable, then new arrival, then mismatch
        step("R7", 1, 0, 18, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 18, 0, 1, 0, 18, 0);
        step("R7", 1, 0, 18, 0, 1, 0, 18, 0);
        step("R7", 1, 0, 18, 0, 1, 1, 18, 999);
        step("R7", 0, 0, 0, 0, 1, 0, 18, 0);
        step("R7", 1, 1, 18, 888, 1, 0, 18, 0);
        step("R7", 1, 0, 18, 0, 1, 0, 19, 0);
        idle("R7");

        // R4 busy inputs ignored in master mode
        nbl = 0; nbr = 0;
        step("R4", 1, 1, 22, 2222, 1, 1, 23, 2323);
        nbl = 1; nbr = 1;
        step("R4", 1, 0, 22, 0, 1, 0, 23, 0);
        idle("R4");

        // R5 slave mode
        nm = 0;
        step("R5", 1, 0, 25, 0, 1, 0, 25, 0);
        nbl = 0;
        step("R5", 1, 1, 26, 6666, 1, 1, 27, 7777);
        step("R5", 1, 0, 26, 0, 1, 0, 27, 0);
        nbl = 1;
        step("R9", 1, 1, 28, 1111, 1, 1, 28, 2828);
        step("R9", 1, 0, 28, 0, 0, 0, 0, 0);
        idle("R5");
        nm = 1;

        // R6 addresses 3 and 35 alias only in the half-depth copy
        step("R6", 1, 0, 3, 0, 1, 1, 35, 3535);
        idle("R6");
        step("R6", 1, 0, 3, 0, 1, 0, 35, 0);
        idle("R6");

        // R8 busy port read still returns data
        step("R8", 1, 0, 40, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 40, 0, 1, 0, 40, 0);
        step("R8", 1, 0, 41, 0, 0, 0, 0, 0);
        idle("R8");

        // R2 and R7 random traffic on a few words, both modes
        for (int i = 0; i < 600; i++) begin
            nm  = (i % 150) < 120;
            nbl = ($urandom % 4) != 0;
            nbr = ($urandom % 4) != 0;
            step((i % 2) ? "R2" : "R7",
                 ($urandom % 4) != 0, $urandom % 2, int'($urandom % 3) + 32 * int'($urandom % 2), int'($urandom % 65536),
                 ($urandom % 4) != 0, $urandom % 2, int'($urandom % 3) + 32 * int'($urandom % 2), int'($urandom % 65536));
        end
        nm = 1; nbl = 1; nbr = 1;
        idle("R9");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule